// File: doc/BRIEF.md
# Dual-Tone Melody Note Sequencer

This block plays short songs stored as packed note words in a private note memory. Software, or a loader, first fills the memory and a small start table that links each song number to the address of its first note. A start strobe with a song number then launches playback: the sequencer reads the note words at consecutive addresses. Each word drives two square-wave tone outputs, an optional percussion gate and a tremolo effect for a duration set by a beat code and a tempo input. Playback continues until a word marked as the last one of its song has played.

The busy output either covers the whole song or only the playing part of each note, selected by an input. Two one-cycle pulses mark the end of every note and the end of the song, so that they can feed an interrupt controller. A new start strobe during playback abandons the current song at once. Song number 0 is the stop command.

Top module: `melody_seq`

## Requirements
- R1: After reset, busy, irq_note, irq_song, tone_a, tone_b and perc_out are all 0. Whenever busy is 0, the three sound outputs are 0.
- R2: Song 0 starts nothing. A start with song 0 while idle leaves busy at 0. A start with any other song reads the start table entry for that song, written through tbl_we/tbl_song/tbl_addr, as the first note address.
- R3: Note word fields: bits 5:0 are the channel A pitch, bits 11:6 the channel B pitch, bits 14:12 the beat code, bit 15 tremolo, bits 17:16 percussion, bit 18 triple and bit 19 end of song. Bits 21:20 are ignored. A note plays for units × (tempo+1) × TICK cycles, where tempo is sampled as the note is loaded. Beat codes 0 to 5 give 1, 2, 3, 4, 6 and 8 units; codes 6 and 7 give 1 unit.
- R4: Pitch index p in 1..41 covers G#3 to C7. With n = p−1, the half period in cycles is (B[n mod 12] << DIV_SHIFT) >> (n / 12), where B = 256, 242, 228, 215, 203, 192, 181, 171, 161, 152, 144, 136. Each tone starts low at the first playing cycle and toggles after each half period.
- R5: A pitch index of 0 or 42..63 is a rest: that tone output stays 0 for the whole note.
- R6: With the triple bit set, both channels use the R4 half period divided by 3, rounded down.
- R7: With the tremolo bit set, both tone outputs are forced to 0 in every playing cycle k (counted from 0 at the note's first playing cycle) where k mod 2^(TREM_LOG+1) ≥ 2^TREM_LOG.
- R8: Percussion code 0 keeps perc_out at 0. Code 1 gives pseudo-random noise for the whole note. Code 2 gives a click that is high for exactly the first CLICK_LEN playing cycles. Code 3 gives noise during the first 4×CLICK_LEN playing cycles.
- R9: With busy_per_note = 1, busy is high exactly during the playing cycles of each note and low for the 2 fetch cycles between notes.
- R10: With busy_per_note = 0, busy rises the cycle after the start and stays high through all fetch and play cycles until the last note ends.
- R11: irq_note pulses for one cycle right after each note's final playing cycle. irq_song pulses with it only after the note marked end of song.
- R12: A start with a nonzero song during playback abandons the current note without any pulse and plays the new song from its first note.
- R13: A start with song 0 during playback stops at once: busy drops the next cycle, and no pulse follows.
- R14: Notes play from consecutive addresses until the end-of-song note has played.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_we | input | 1 | Note memory write strobe |
| mem_addr | input | ADDR_W | Note memory write address |
| mem_data | input | 22 | Note word to write |
| tbl_we | input | 1 | Start table write strobe |
| tbl_song | input | SONG_W | Song entry to write |
| tbl_addr | input | ADDR_W | First note address of that song |
| start | input | 1 | Start/stop strobe |
| song | input | SONG_W | Song number for start, 0 = stop |
| tempo | input | 4 | Tempo setting, 0 fastest |
| busy_per_note | input | 1 | 1: busy per note, 0: busy per song |
| tone_a | output | 1 | Channel A square wave |
| tone_b | output | 1 | Channel B square wave |
| perc_out | output | 1 | Percussion gate |
| busy | output | 1 | Playback busy flag |
| irq_note | output | 1 | End-of-note pulse |
| irq_song | output | 1 | End-of-song pulse |

## Verification
The hardest case is an abort that lands in the middle of a note. The strobe has to arrive while the sequencer is in its play state, neither during a fetch nor in the final cycle. The bench waits for busy to rise in per-note mode and then counts a few playing cycles before it issues the new start. It does this once with a new song, then checks the length of that song's first note and that no pulse came from the abandoned one. It does it again with song 0 and watches for silence afterwards. Tremolo and click windows are reached by recording every output cycle of a long single-note song and comparing the cycle indices against the formulas.

// File: rtl/melody_seq.sv
module melody_seq #(
  parameter int ADDR_W    = 10,
  parameter int SONG_W    = 5,
  parameter int TICK      = 4,
  parameter int DIV_SHIFT = 0,
  parameter int TREM_LOG  = 5,
  parameter int CLICK_LEN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [21:0]       mem_data,
  input  logic              tbl_we,
  input  logic [SONG_W-1:0] tbl_song,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic              start,
  input  logic [SONG_W-1:0] song,
  input  logic [3:0]        tempo,
  input  logic              busy_per_note,
  output logic              tone_a,
  output logic              tone_b,
  output logic              perc_out,
  output logic              busy,
  output logic              irq_note,
  output logic              irq_song
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SONGS  = 1 << SONG_W;
  localparam int DUR_W  = $clog2(128 * TICK) + 1;
  localparam int HALF_W = 9 + DIV_SHIFT;
  localparam int CK_W   = $clog2(4 * CLICK_LEN + 1);
  localparam logic [CK_W-1:0] CK_CLICK = CK_W'(CLICK_LEN);
  localparam logic [CK_W-1:0] CK_LONG  = CK_W'(4 * CLICK_LEN);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOAD, S_PLAY} st_t;

  function automatic logic [HALF_W-1:0] half_of(input logic [5:0] p, input logic tri3);
    int n, b, v;
    n = int'(p) - 1;
    case (n % 12)
      0: b = 256;  1: b = 242;  2: b = 228;  3: b = 215;
      4: b = 203;  5: b = 192;  6: b = 181;  7: b = 171;
      8: b = 161;  9: b = 152; 10: b = 144;
      default: b = 136;
    endcase
    v = (b << DIV_SHIFT) >> (n / 12);
    if (tri3) v = v / 3;
    return HALF_W'(v);
  endfunction

  function automatic int units_of(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 6;
      3'd5: return 8;
      default: return 1;
    endcase
  endfunction

  logic [21:0]       mem [DEPTH];
  logic [ADDR_W-1:0] tbl [SONGS];
  logic [21:0]       rd_q;
  logic [19:0]       note;
  st_t               st;
  logic [ADDR_W-1:0] addr;
  logic [DUR_W-1:0]  dur_cnt;
  logic [HALF_W-1:0] half_a, half_b, cnt_a, cnt_b;
  logic              ta, tb;
  logic [TREM_LOG:0] el;
  logic [CK_W-1:0]   ck;
  logic [15:0]       lfsr;

  wire unused_rsv = ^rd_q[21:20];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_data;
    if (tbl_we) tbl[tbl_song] <= tbl_addr;
    rd_q <= mem[addr];
  end

  wire play   = (st == S_PLAY);
  wire va     = (note[5:0]  != 6'd0) && (note[5:0]  <= 6'd41);
  wire vb     = (note[11:6] != 6'd0) && (note[11:6] <= 6'd41);
  wire gate   = !note[15] || !el[TREM_LOG];
  wire [DUR_W-1:0] dur_ld =
    DUR_W'(units_of(rd_q[14:12]) * (int'(tempo) + 1) * TICK - 1);
  wire [HALF_W-1:0] ha_ld = half_of(rd_q[5:0],  rd_q[18]);
  wire [HALF_W-1:0] hb_ld = half_of(rd_q[11:6], rd_q[18]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr     <= '0;
      note     <= '0;
      dur_cnt  <= '0;
      half_a   <= '0;
      half_b   <= '0;
      cnt_a    <= '0;
      cnt_b    <= '0;
      ta       <= 1'b0;
      tb       <= 1'b0;
      el       <= '0;
      ck       <= '0;
      irq_note <= 1'b0;
      irq_song <= 1'b0;
    end else begin
      irq_note <= 1'b0;
      irq_song <= 1'b0;
      if (start) begin
        if (song == '0) st <= S_IDLE;
        else begin
          addr <= tbl[song];
          st   <= S_FETCH;
        end
      end else begin
        case (st)
          S_FETCH: st <= S_LOAD;
          S_LOAD: begin
            note    <= rd_q[19:0];
            dur_cnt <= dur_ld;
            half_a  <= ha_ld;
            half_b  <= hb_ld;
            cnt_a   <= ha_ld - HALF_W'(1);
            cnt_b   <= hb_ld - HALF_W'(1);
            ta      <= 1'b0;
            tb      <= 1'b0;
            el      <= '0;
            ck      <= '0;
            st      <= S_PLAY;
          end
          S_PLAY: begin
            el <= el + 1'b1;
            if (ck != CK_LONG) ck <= ck + 1'b1;
            if (cnt_a == '0) begin
              ta    <= ~ta;
              cnt_a <= half_a - HALF_W'(1);
            end else cnt_a <= cnt_a - 1'b1;
            if (cnt_b == '0) begin
              tb    <= ~tb;
              cnt_b <= half_b - HALF_W'(1);
            end else cnt_b <= cnt_b - 1'b1;
            if (dur_cnt == '0) begin
              irq_note <= 1'b1;
              irq_song <= note[19];
              if (note[19]) st <= S_IDLE;
              else begin
                addr <= addr + ADDR_W'(1);
                st   <= S_FETCH;
              end
            end else dur_cnt <= dur_cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  logic perc_sel;
  always_comb begin
    case (note[17:16])
      2'd1:    perc_sel = lfsr[0];
      2'd2:    perc_sel = (ck < CK_CLICK);
      2'd3:    perc_sel = lfsr[0] && (ck < CK_LONG);
      default: perc_sel = 1'b0;
    endcase
  end

  assign tone_a   = play && va && ta && gate;
  assign tone_b   = play && vb && tb && gate;
  assign perc_out = play && perc_sel;
  assign busy     = busy_per_note ? play : (st != S_IDLE);
endmodule

module melody_seq_chk #(
  parameter int SONG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [SONG_W-1:0] song,
  input logic              busy_per_note,
  input logic              busy,
  input logic              tone_a,
  input logic              tone_b,
  input logic              perc_out,
  input logic              irq_note,
  input logic              irq_song
);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tone_a && !tone_b && !perc_out));

  a_r11_note_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_note |=> !irq_note);

  a_r11_song_with_note: assert property (@(posedge clk) disable iff (!rst_n)
    irq_song |-> irq_note);

  a_r9_busy_low_at_note_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_per_note && irq_note) |-> !busy);

  a_r10_busy_low_at_song_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_per_note && irq_song && !start) |-> !busy);

  a_r13_stop_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && song == '0) |=> (!busy && !irq_note));

  a_r12_start_song_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && song != '0 && !busy_per_note) |=> (busy || busy_per_note));
endmodule

bind melody_seq melody_seq_chk #(.SONG_W(SONG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .song(song),
  .busy_per_note(busy_per_note), .busy(busy), .tone_a(tone_a),
  .tone_b(tone_b), .perc_out(perc_out), .irq_note(irq_note), .irq_song(irq_song)
);

// File: tb/sim_melody_seq.sv
`timescale 1ns/1ps
module sim_melody_seq;
  localparam int AW = 10;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_we = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [21:0]   mem_data = '0;
  logic          tbl_we = 1'b0;
  logic [SW-1:0] tbl_song = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic          start = 1'b0;
  logic [SW-1:0] song = '0;
  logic [3:0]    tempo = '0;
  logic          busy_per_note = 1'b1;
  logic          tone_a, tone_b, perc_out, busy, irq_note, irq_song;

  always #2 clk = ~clk;

  melody_seq u0 (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .tbl_we(tbl_we), .tbl_song(tbl_song),
    .tbl_addr(tbl_addr), .start(start), .song(song), .tempo(tempo),
    .busy_per_note(busy_per_note), .tone_a(tone_a), .tone_b(tone_b),
    .perc_out(perc_out), .busy(busy), .irq_note(irq_note), .irq_song(irq_song)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  mon_en = 1'b0;
  typedef struct { int dur; bit last; } exp_t;
  exp_t sbq[$];
  bit  ra [0:1023];
  bit  rb [0:1023];
  bit  rp [0:1023];
  int  rlen;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_half(int p, bit t3);
    int n, b, v;
    n = p - 1;
    case (n % 12)
      0: b = 256;  1: b = 242;  2: b = 228;  3: b = 215;
      4: b = 203;  5: b = 192;  6: b = 181;  7: b = 171;
      8: b = 161;  9: b = 152; 10: b = 144;
      default: b = 136;
    endcase
    v = b >> (n / 12);
    if (t3) v = v / 3;
    return v;
  endfunction

  function automatic logic [21:0] nw(int pa, int pb, int beat, int trem, int perc, int t3, int eos);
    logic [5:0] a6, b6;
    logic [2:0] bt;
    logic [1:0] pc;
    a6 = pa[5:0]; b6 = pb[5:0]; bt = beat[2:0]; pc = perc[1:0];
    return {2'b11, eos[0], t3[0], pc, trem[0], bt, b6, a6};
  endfunction

  function automatic bit sel(int w, int k);
    case (w)
      0: return ra[k];
      1: return rb[k];
      default: return rp[k];
    endcase
  endfunction

  function automatic int edge_at(int w, int from, bit val);
    for (int k = from; k < rlen; k++) if (sel(w, k) == val) return k;
    return -1;
  endfunction

  function automatic int ones(int w, int from, int upto);
    int c;
    c = 0;
    for (int k = from; k < upto && k < rlen; k++) if (sel(w, k)) c++;
    return c;
  endfunction

  task automatic wr_mem(int a, logic [21:0] d);
    @(negedge clk); mem_we = 1'b1; mem_addr = AW'(a); mem_data = d;
    @(negedge clk); mem_we = 1'b0;
  endtask

  task automatic wr_tbl(int s, int a);
    @(negedge clk); tbl_we = 1'b1; tbl_song = SW'(s); tbl_addr = AW'(a);
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic go(int s);
    @(negedge clk); start = 1'b1; song = SW'(s);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic sb_push(int d, bit last);
    exp_t e;
    e.dur = d; e.last = last;
    sbq.push_back(e);
  endtask

  task automatic wait_drain(int lim);
    for (int i = 0; i < lim && sbq.size() != 0; i++) tick();
    repeat (3) tick();
    chk_eq("R14", "notes left unplayed", sbq.size(), 0);
  endtask

  task automatic capture();
    int k;
    k = 0;
    for (int i = 0; i < 200 && !busy; i++) tick();
    while (busy && k < 1024) begin
      ra[k] = tone_a; rb[k] = tone_b; rp[k] = perc_out;
      k++;
      tick();
    end
    rlen = k;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : monitor
    int run;
    bit prev;
    exp_t e;
    run = 0; prev = 1'b0;
    forever begin
      tick();
      if (mon_en && busy) run++;
      else if (mon_en && prev) begin
        if (sbq.size() == 0) chk_eq("R11", "unexpected note end", 1, 0);
        else begin
          e = sbq.pop_front();
          chk_eq("R3", "note length", run, e.dur);
          chk_eq("R11", "irq_note at note end", int'(irq_note), 1);
          chk_eq("R11", "irq_song at note end", int'(irq_song), int'(e.last));
        end
        run = 0;
      end else run = 0;
      prev = mon_en && busy;
    end
  end

  initial begin
    #600000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin : main
    int cnt, irqs, busys, bad, rise, fall;
    repeat (3) @(negedge clk);
    tick();
    // R1 reset state
    chk_eq("R1", "busy in reset", int'(busy), 0);
    chk_eq("R1", "irq in reset", int'(irq_note | irq_song), 0);
    chk_eq("R1", "sound in reset", int'(tone_a | tone_b | perc_out), 0);
    @(negedge clk); rst_n = 1'b1;

    wr_mem(0,  nw(13, 20, 0, 0, 0, 0, 0));
    wr_mem(1,  nw(13, 20, 3, 0, 0, 0, 0));
    wr_mem(2,  nw(13, 20, 5, 0, 0, 0, 1));
    wr_mem(10, nw(13, 0, 1, 0, 0, 0, 0));
    wr_mem(11, nw(13, 0, 2, 0, 0, 0, 0));
    wr_mem(12, nw(13, 0, 4, 0, 0, 0, 0));
    wr_mem(13, nw(13, 0, 6, 0, 0, 0, 0));
    wr_mem(14, nw(13, 0, 7, 0, 0, 0, 1));
    wr_mem(20, nw(13, 20, 5, 0, 0, 0, 1));
    wr_mem(21, nw(13, 20, 5, 0, 0, 1, 1));
    wr_mem(22, nw(0, 50, 5, 0, 0, 0, 1));
    wr_mem(23, nw(41, 0, 5, 1, 0, 0, 1));
    wr_mem(24, nw(0, 0, 5, 0, 2, 0, 1));
    wr_mem(25, nw(13, 0, 5, 0, 0, 0, 1));
    wr_mem(26, nw(0, 0, 5, 0, 1, 0, 1));
    wr_tbl(1, 0);
    for (int s = 2; s <= 9; s++) wr_tbl(s, (s == 2) ? 10 : 18 + s - 1);

    // R2 song 0 while idle
    busy_per_note = 1'b0;
    go(0);
    busys = 0;
    repeat (10) begin tick(); if (busy) busys++; end
    chk_eq("R2", "busy after song 0 start", busys, 0);

    // R3 R9 R11 R14 song 1, tempo 2: 1,4,8 units x 3 x 4
    @(negedge clk); busy_per_note = 1'b1; tempo = 4'd2; mon_en = 1'b1;
    sb_push(12, 0); sb_push(48, 0); sb_push(96, 1);
    go(1);
    wait_drain(1000);

    // R3 beat codes 1,2,4,6,7 at tempo 0
    @(negedge clk); tempo = 4'd0;
    sb_push(8, 0); sb_push(12, 0); sb_push(24, 0); sb_push(4, 0); sb_push(4, 1);
    go(2);
    wait_drain(1000);
    @(negedge clk); mon_en = 1'b0;

    // R9 gap between notes is 2 cycles
    go(2);
    for (int i = 0; i < 50 && !busy; i++) tick();
    while (busy) tick();
    cnt = 0;
    while (!busy && cnt < 50) begin cnt++; tick(); end
    chk_eq("R9", "gap between notes", cnt, 2);
    for (int i = 0; i < 200 && !irq_song; i++) tick();
    repeat (3) tick();

    // R4 tone half periods
    @(negedge clk); tempo = 4'd15;
    go(3); capture();
    chk_eq("R3", "long note length", rlen, 512);
    rise = edge_at(0, 0, 1); fall = edge_at(0, rise, 0);
    chk_eq("R4", "tone_a first rise", rise, exp_half(13, 0));
    chk_eq("R4", "tone_a first fall", fall, 2 * exp_half(13, 0));
    rise = edge_at(1, 0, 1); fall = edge_at(1, rise, 0);
    chk_eq("R4", "tone_b first rise", rise, exp_half(20, 0));
    chk_eq("R4", "tone_b first fall", fall, 2 * exp_half(20, 0));

    // R6 triple
    go(4); capture();
    rise = edge_at(0, 0, 1); fall = edge_at(0, rise, 0);
    chk_eq("R6", "tone_a triple rise", rise, exp_half(13, 1));
    chk_eq("R6", "tone_a triple fall", fall, 2 * exp_half(13, 1));
    chk_eq("R6", "tone_b triple rise", edge_at(1, 0, 1), exp_half(20, 1));

    // R5 rests
    go(5); capture();
    chk_eq("R5", "rest note length", rlen, 512);
    chk_eq("R5", "tone_a during pitch 0", ones(0, 0, 1024), 0);
    chk_eq("R5", "tone_b during pitch 50", ones(1, 0, 1024), 0);

    // R7 tremolo, window 32 at TREM_LOG 5
    go(6); capture();
    bad = 0;
    for (int k = 0; k < rlen; k++) if ((k % 64) >= 32 && ra[k]) bad++;
    chk_eq("R7", "tone_a high in muted window", bad, 0);
    chk_eq("R7", "tone_a first rise with tremolo", edge_at(0, 0, 1), exp_half(41, 0));

    // R8 percussion, CLICK_LEN 6
    go(7); capture();
    chk_eq("R8", "click high count", ones(2, 0, 1024), 6);
    chk_eq("R8", "click in first cycles", ones(2, 0, 6), 6);
    go(8); capture();
    chk_eq("R8", "no percussion", ones(2, 0, 1024), 0);
    go(9); capture();
    cnt = ones(2, 0, 1024);
    chk_eq("R8", "noise has highs", int'(cnt > 0), 1);
    chk_eq("R8", "noise has lows", int'(cnt < rlen), 1);

    // R10 per-song busy: song 1 at tempo 2, LOAD seen first
    @(negedge clk); tempo = 4'd2; busy_per_note = 1'b0;
    go(1);
    cnt = 0;
    tick();
    while (busy && cnt < 2000) begin cnt++; tick(); end
    chk_eq("R10", "song busy length", cnt, 161);
    chk_eq("R11", "irq_song at song end", int'(irq_song), 1);
    repeat (3) tick();

    // R12 restart during a note
    @(negedge clk); busy_per_note = 1'b1;
    go(1);
    for (int i = 0; i < 50 && !busy; i++) tick();
    repeat (5) tick();
    go(2);
    irqs = 0;
    for (int i = 0; i < 50 && !busy; i++) begin if (irq_note) irqs++; tick(); end
    chk_eq("R12", "pulse from abandoned note", irqs, 0);
    cnt = 0;
    while (busy && cnt < 500) begin cnt++; tick(); end
    chk_eq("R12", "first note of new song", cnt, 24);

    // R13 stop during a note
    for (int i = 0; i < 50 && !busy; i++) tick();
    repeat (3) tick();
    go(0);
    tick();
    chk_eq("R13", "busy after stop", int'(busy), 0);
    irqs = 0; busys = 0;
    repeat (30) begin tick(); if (irq_note) irqs++; if (busy) busys++; end
    chk_eq("R13", "pulses after stop", irqs, 0);
    chk_eq("R13", "busy after stop window", busys, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule